// File: doc/BRIEF.md
# Reflected Decimal to 6-3-1-1 Weighted Code Converter

This block takes one decimal digit written in a four-bit reflected decimal code and produces the same digit in a four-bit weighted code whose bit weights are 6, 3, 1 and 1. Alongside the weighted word it produces a legality flag. The flag is high when the input is one of the ten code words that stand for a digit, and low for the other six input words. A weighted word that belongs to an illegal input is forced to zero, so a caller never sees a value that was left open during minimisation.

The conversion logic is purely combinational. A parameter chooses whether the result goes straight to the ports or through an output register. In the registered form the register loads when the input strobe is high and is cleared by a synchronous reset. A ready signal marks the cycle in which a freshly captured result is present.

Top module: `refl6311_conv`

## Requirements
- R1: The legality flag `legal_o` is 1 for exactly these ten inputs `code_i` (bit 3 first), with their digits: 0000=0, 0001=1, 0011=2, 0010=3, 0110=4, 1110=5, 1010=6, 1011=7, 1001=8, 1000=9.
- R2: `legal_o` is 0 for the six inputs 0100, 0101, 0111, 1100, 1101 and 1111.
- R3: For a legal input, `wt_o` gives the digit with weight 6 on bit 3, 3 on bit 2, and 1 on each of bits 1 and 0. The words are 0=0000, 1=0001, 2=0011, 3=0100, 4=0101, 5=0111, 6=1000, 7=1001, 8=1011, 9=1100, so 6·bit3 + 3·bit2 + bit1 + bit0 equals the digit.
- R4: For an illegal input, `wt_o` is 0000.
- R5: With the registered output selected (`REG_OUT`=1), a strobe high at a rising edge loads the converted result, which appears on `legal_o` and `wt_o` after that edge.
- R6: `rst` high at a rising edge sets `legal_o`, `wt_o` and `rdy_o` to 0 after that edge.
- R7: In the registered form, an edge with the strobe low leaves `legal_o` and `wt_o` unchanged.
- R8: `rdy_o` is 1 in the cycle after an edge that accepted a strobe and 0 otherwise, which includes every cycle from reset until the first strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous reset, active high |
| stb_i | input | 1 | Input strobe: `code_i` is valid |
| code_i | input | 4 | Reflected decimal code word, bit 3 most significant |
| legal_o | output | 1 | High when the input word is legal |
| wt_o | output | 4 | Weighted digit: bit 3 weight 6, bit 2 weight 3, bits 1 and 0 weight 1 |
| rdy_o | output | 1 | Result captured in the previous cycle |

## Verification
The bench builds the block with the default `REG_OUT`=1. This covers the conversion logic and the register stage together, including capture, hold, clearing and the ready timing. Because the input has only four bits, all sixteen words can be swept. Each legal word is checked by summing the weighted bits and comparing the sum with the digit the bench decodes. Each illegal word is checked for a low flag and an all-zero output.

// File: rtl/refl6311_pkg.sv
package refl6311_pkg;
    localparam int CODE_W = 4;
    localparam int WT_W   = 4;

    typedef struct packed {
        logic            legal;
        logic [WT_W-1:0] wt;
    } conv_res_t;
endpackage

// File: rtl/refl6311_decode.sv
module refl6311_decode
    import refl6311_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output conv_res_t         res
);
    logic a, b, c, d, ac_x;
    logic [WT_W-1:0] raw;

    always_comb begin
        a    = code[3];
        b    = code[2];
        c    = code[1];
        d    = code[0];
        ac_x = a ^ c;
        raw[3] = a & ~b;
        raw[2] = b | (~d & ac_x);
        raw[1] = (a & b) | (d & ac_x);
        raw[0] = b | d;
        res.legal = ~b | (c & ~d);
        res.wt    = res.legal ? raw : '0;
    end

    always_comb begin
        if (!res.legal) begin
            assert_illegal_zero_R4: assert (res.wt == '0);
        end
        if (res.legal) begin
            assert_digit_range_R3: assert ((6 * res.wt[3] + 3 * res.wt[2] + res.wt[1] + res.wt[0]) <= 9);
        end
    end
endmodule

// File: rtl/refl6311_ostage.sv
module refl6311_ostage
    import refl6311_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      stb,
    input  conv_res_t res_in,
    output conv_res_t res_out,
    output logic      rdy
);
    generate
        if (REG_OUT) begin : g_reg
            typedef struct packed {
                conv_res_t res;
                logic      rdy;
            } ost_t;

            ost_t st_d, st_q;

            always_comb begin
                st_d     = st_q;
                st_d.rdy = stb;
                if (stb) st_d.res = res_in;
                if (rst) st_d = '0;
            end

            always_ff @(posedge clk) begin
                st_q <= st_d;
            end

            assign res_out = st_q.res;
            assign rdy     = st_q.rdy;

            assert_rdy_follows_R8: assert property (@(posedge clk) disable iff (rst)
                stb |=> rdy);
            assert_rdy_quiet_R8: assert property (@(posedge clk) disable iff (rst)
                !stb |=> !rdy);
            assert_reset_clear_R6: assert property (@(posedge clk)
                rst |=> (res_out == '0 && !rdy));
            assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
                stb |=> res_out == $past(res_in));
            assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
                !stb |=> $stable(res_out));
        end else begin : g_pass
            assign res_out = res_in;
            assign rdy     = stb;
        end
    endgenerate
endmodule

// File: rtl/refl6311_conv.sv
module refl6311_conv
    import refl6311_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              legal_o,
    output logic [WT_W-1:0]   wt_o,
    output logic              rdy_o
);
    conv_res_t comb_res, out_res;

    refl6311_decode u_dec (
        .code (code_i),
        .res  (comb_res)
    );

    refl6311_ostage #(.REG_OUT(REG_OUT)) u_ost (
        .clk     (clk),
        .rst     (rst),
        .stb     (stb_i),
        .res_in  (comb_res),
        .res_out (out_res),
        .rdy     (rdy_o)
    );

    assign legal_o = out_res.legal;
    assign wt_o    = out_res.wt;
endmodule

// File: tb/refl6311_conv_test.sv
module refl6311_conv_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stb = 1'b0;
    logic [3:0] code = 4'd0;
    logic       legal;
    logic [3:0] wt;
    logic       rdy;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    refl6311_conv #(.REG_OUT(1'b1)) uut (
        .clk(clk), .rst(rst), .stb_i(stb), .code_i(code),
        .legal_o(legal), .wt_o(wt), .rdy_o(rdy)
    );

    // digit from code, -1 for illegal words (R1, R2)
    function automatic int digit_of(input logic [3:0] w);
        case (w)
            4'b0000: return 0;  4'b0001: return 1;
            4'b0011: return 2;  4'b0010: return 3;
            4'b0110: return 4;  4'b1110: return 5;
            4'b1010: return 6;  4'b1011: return 7;
            4'b1001: return 8;  4'b1000: return 9;
            default: return -1;
        endcase
    endfunction

    function automatic logic [3:0] wt_of(input int dg);
        case (dg)
            0: return 4'b0000; 1: return 4'b0001; 2: return 4'b0011;
            3: return 4'b0100; 4: return 4'b0101; 5: return 4'b0111;
            6: return 4'b1000; 7: return 4'b1001; 8: return 4'b1011;
            default: return 4'b1100;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] held_wt;
        logic       held_legal;
        repeat (3) @(negedge clk);
        check("R6 reset legal", int'(legal), 0);
        check("R6 reset wt", int'(wt), 0);
        check("R6 reset rdy", int'(rdy), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 no rdy before first strobe", int'(rdy), 0);

        for (int i = 0; i < 16; i++) begin
            int dg;
            code = 4'(i);
            stb  = 1'b1;
            @(negedge clk);
            stb  = 1'b0;
            dg = digit_of(4'(i));
            check("R5/R8 rdy after strobe", int'(rdy), 1);
            if (dg >= 0) begin
                check("R1 legal flag", int'(legal), 1);
                check("R3 weighted sum", 6*wt[3] + 3*wt[2] + wt[1] + wt[0], dg);
                check("R3 exact word", int'(wt), int'(wt_of(dg)));
            end else begin
                check("R2 illegal flag", int'(legal), 0);
                check("R4 zero word", int'(wt), 0);
            end
            held_wt = wt;
            held_legal = legal;
            code = ~4'(i);
            @(negedge clk);
            check("R8 rdy drops", int'(rdy), 0);
            check("R7 hold wt", int'(wt), int'(held_wt));
            check("R7 hold legal", int'(legal), int'(held_legal));
        end

        code = 4'b1000;
        stb  = 1'b1;
        @(negedge clk);
        stb  = 1'b0;
        check("R5 capture 9", int'(wt), 12);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R6 reset clears wt", int'(wt), 0);
        check("R6 reset clears legal", int'(legal), 0);
        check("R6 reset clears rdy", int'(rdy), 0);

        code = 4'b0110;
        stb  = 1'b1;
        rst  = 1'b1;
        @(negedge clk);
        rst  = 1'b0;
        stb  = 1'b0;
        check("R6 reset wins over strobe", int'(wt), 0);
        check("R6 reset wins over strobe rdy", int'(rdy), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule